// File: doc/BRIEF.md
# USB OTG Bus Event Interrupt Monitor

This block observes the decoded USB line state and a handful of OTG session signals. It turns each noteworthy condition into a sticky flag inside one 16-bit interrupt status word. The conditions are a long SE0, a bus that stays idle long enough to count as suspend, a resume (J to K) seen while suspended, a session request from the far end, a time-out from an external OTG timer, and any toggle of the remote-connect, A-session-valid or B-session-valid levels. Software reads the word from a single register port. It clears individual flags by writing ones to them. An interrupt line stays high while any flag is set.

The millisecond windows come from a parameter that gives the number of clock cycles in one millisecond, so a bench can shrink them. All inputs are expected to be synchronous to `clk`. Line states are coded as 00 = SE0, 01 = J (idle), 10 = K, 11 = SE1. SE1 is treated as a non-idle state.

Top module: `otg_evt_irq`

## Requirements
- R1: The status word has flags only at bits 10 to 3. Bits 15 to 11 and bits 2 to 0 always read 0, even after a write of all ones.
- R2: Every flag is sticky. A write with bit n = 1 clears flag n. A write with bit n = 0 leaves flag n unchanged.
- R3: Bit 9 sets when the line state has been SE0 for more than SE0_MS milliseconds, that is for SE0_MS*CYC_PER_MS+1 consecutive samples. A run of exactly SE0_MS*CYC_PER_MS samples does not set it.
- R4: Bit 6 sets when the line has been J (idle) for IDLE_MS*CYC_PER_MS+1 consecutive samples, and the port then counts as suspended. Any non-J line state ends the suspended condition.
- R5: Bit 7 sets on a J-to-K transition only while the port is suspended. The same transition outside suspend, or a K that follows a non-J state, leaves bit 7 clear.
- R6: Bit 8 sets on a session-request pulse. When the select input is 0 only the VBUS-pulsing input counts, and when it is 1 only the data-line-pulsing input counts.
- R7: Bits 5, 4 and 3 set on any change, rising or falling, of the remote-connect, B-session-valid and A-session-valid inputs respectively.
- R8: Bit 10 sets in any cycle in which the timer time-out input is high.
- R9: If an event and a write-1 clear of the same bit occur in the same cycle, the bit stays set.
- R10: Reset clears every flag and the interrupt output. The interrupt output is high exactly when at least one flag is set.
- R11: The SE0 and idle counters restart whenever the line state changes. Each sets its flag at most once per continuous run, so a flag cleared during a long run stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_st_i | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| tmr_tmo_i | input | 1 | OTG timer time-out pulse |
| srp_vbus_i | input | 1 | Session request seen as VBUS pulsing |
| srp_dline_i | input | 1 | Session request seen as data-line pulsing |
| srp_sel_dline_i | input | 1 | 1 selects data-line pulsing as the request source, 0 selects VBUS pulsing |
| rmt_conn_i | input | 1 | Remote-connect level |
| b_sess_vld_i | input | 1 | B-session-valid level |
| a_sess_vld_i | input | 1 | A-session-valid level |
| wr_en_i | input | 1 | Write strobe for the status word (write-1-to-clear) |
| wr_data_i | input | 16 | Clear mask: a 1 clears that flag |
| stat_o | output | 16 | Registered interrupt status word |
| irq_o | output | 1 | Registered interrupt, high while any flag is set |

## Verification
The time-out, session-request and level-change flags appear on `stat_o` at the first rising edge that samples the stimulus. A write clear takes effect at the edge that samples `wr_en_i`, and `irq_o` always moves on the same edge as the word. The SE0 and suspend flags appear one edge after the (limit+1)th consecutive equal sample. The resume flag appears one edge after K is first sampled. The bench's behavioural model steps on each rising edge using these latencies and is compared with both outputs at every falling edge. The directed checks read the word only after a scenario has settled for several cycles, so no check depends on an exact edge by chance.

// File: rtl/otg_evt_pkg.sv
package otg_evt_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_st_e;

  localparam int unsigned STAT_W   = 16;
  localparam int unsigned BIT_TMO  = 10;
  localparam int unsigned BIT_SE0  = 9;
  localparam int unsigned BIT_SRP  = 8;
  localparam int unsigned BIT_RSM  = 7;
  localparam int unsigned BIT_SUSP = 6;
  localparam int unsigned BIT_LVL0 = 3;   // levels occupy BIT_LVL0 .. BIT_LVL0+2
  localparam int unsigned N_LVL    = 3;

  localparam logic [STAT_W-1:0] STAT_VALID = 16'h07F8;

endpackage

// File: rtl/otg_line_timer.sv
module otg_line_timer
  import otg_evt_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 48000,
  parameter int unsigned SE0_MS     = 2,
  parameter int unsigned IDLE_MS    = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  line_st_e line_i,
  output logic     se0_hit_o,
  output logic     susp_hit_o,
  output logic     resume_hit_o
);

  localparam int unsigned SE0_LIM  = SE0_MS * CYC_PER_MS;
  localparam int unsigned IDLE_LIM = IDLE_MS * CYC_PER_MS;
  localparam int unsigned CNT_MAX  = ((SE0_LIM > IDLE_LIM) ? SE0_LIM : IDLE_LIM) + 1;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SE0_CMP  = CNT_W'(SE0_LIM);
  localparam logic [CNT_W-1:0] IDLE_CMP = CNT_W'(IDLE_LIM);
  localparam logic [CNT_W-1:0] SAT_CMP  = CNT_W'(CNT_MAX);

  line_st_e         ls_q;
  line_st_e         ls_prev;
  logic [CNT_W-1:0] run_q;
  logic             susp_q;

  // run_q holds (consecutive equal samples - 1) of the current line state
  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q    <= LS_SE0;
      ls_prev <= LS_SE0;
      run_q   <= '0;
    end else begin
      ls_prev <= ls_q;
      if (line_i != ls_q) begin
        ls_q  <= line_i;
        run_q <= '0;
      end else if (run_q != SAT_CMP) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  always_comb begin
    se0_hit_o    = (ls_q == LS_SE0) && (run_q == SE0_CMP);
    susp_hit_o   = (ls_q == LS_J)   && (run_q == IDLE_CMP);
    resume_hit_o = susp_q && (ls_q == LS_K) && (ls_prev == LS_J);
  end

  always_ff @(posedge clk) begin
    if (rst)                 susp_q <= 1'b0;
    else if (susp_hit_o)     susp_q <= 1'b1;
    else if (ls_q != LS_J)   susp_q <= 1'b0;
  end

  p_se0_once_r11: assert property (@(posedge clk) disable iff (rst)
    se0_hit_o |=> !se0_hit_o);
  p_idle_once_r11: assert property (@(posedge clk) disable iff (rst)
    susp_hit_o |=> !susp_hit_o);
  p_susp_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_q) |-> (ls_prev == LS_J));
  p_susp_leave_r4: assert property (@(posedge clk) disable iff (rst)
    (susp_q && ls_q != LS_J) |=> !susp_q);
  p_resume_edge_r5: assert property (@(posedge clk) disable iff (rst)
    resume_hit_o |-> (run_q == '0));

endmodule

// File: rtl/otg_lvl_change.sv
module otg_lvl_change #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);

  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g] <= 1'b0;
      else     lvl_q[g] <= lvl_i[g];
    end

    assign chg_o[g] = lvl_i[g] ^ lvl_q[g];

    p_chg_track_r7: assert property (@(posedge clk) disable iff (rst)
      chg_o[g] |=> (lvl_q[g] != $past(lvl_q[g])));
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !chg_o[g] |=> $stable(lvl_q[g]));
  end

endmodule

// File: rtl/otg_w1c_reg.sv
module otg_w1c_reg #(
  parameter int unsigned     W     = 16,
  parameter logic [W-1:0]    VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic         any_o
);

  logic [W-1:0] nxt;

  // event wins over a simultaneous clear
  always_comb nxt = ((q_o & ~(clr_en_i ? clr_i : '0)) | set_i) & VALID;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= '0;
      any_o <= 1'b0;
    end else begin
      q_o   <= nxt;
      any_o <= |nxt;
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (q_o & ~VALID) == '0);
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_en_i |=> ((q_o & $past(q_o)) == $past(q_o)));
  p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & VALID)) |=> ((q_o & $past(set_i & VALID)) == $past(set_i & VALID)));
  p_irq_any_r10: assert property (@(posedge clk) disable iff (rst)
    any_o == (|q_o));

endmodule

// File: rtl/otg_evt_irq.sv
module otg_evt_irq
  import otg_evt_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 48000,
  parameter int unsigned SE0_MS     = 2,
  parameter int unsigned IDLE_MS    = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  line_st_i,
  input  logic        tmr_tmo_i,
  input  logic        srp_vbus_i,
  input  logic        srp_dline_i,
  input  logic        srp_sel_dline_i,
  input  logic        rmt_conn_i,
  input  logic        b_sess_vld_i,
  input  logic        a_sess_vld_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] stat_o,
  output logic        irq_o
);

  logic             se0_hit, susp_hit, rsm_hit, srp_hit;
  logic [N_LVL-1:0] lvl_in, lvl_chg;
  logic [STAT_W-1:0] set_vec;

  otg_line_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .SE0_MS     (SE0_MS),
    .IDLE_MS    (IDLE_MS)
  ) u_line (
    .clk          (clk),
    .rst          (rst),
    .line_i       (line_st_e'(line_st_i)),
    .se0_hit_o    (se0_hit),
    .susp_hit_o   (susp_hit),
    .resume_hit_o (rsm_hit)
  );

  // index 0 -> A-session, 1 -> B-session, 2 -> remote-connect
  assign lvl_in = {rmt_conn_i, b_sess_vld_i, a_sess_vld_i};

  otg_lvl_change #(.N(N_LVL)) u_lvl (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (lvl_in),
    .chg_o (lvl_chg)
  );

  assign srp_hit = srp_sel_dline_i ? srp_dline_i : srp_vbus_i;

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_TMO]  = tmr_tmo_i;
    set_vec[BIT_SE0]  = se0_hit;
    set_vec[BIT_SRP]  = srp_hit;
    set_vec[BIT_RSM]  = rsm_hit;
    set_vec[BIT_SUSP] = susp_hit;
    set_vec[BIT_LVL0 +: N_LVL] = lvl_chg;
  end

  otg_w1c_reg #(.W(STAT_W), .VALID(STAT_VALID)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_vec),
    .clr_en_i (wr_en_i),
    .clr_i    (wr_data_i),
    .q_o      (stat_o),
    .any_o    (irq_o)
  );

  p_srp_select_r6: assert property (@(posedge clk) disable iff (rst)
    (srp_sel_dline_i && srp_dline_i) |=> stat_o[BIT_SRP]);
  p_timeout_r8: assert property (@(posedge clk) disable iff (rst)
    tmr_tmo_i |=> stat_o[BIT_TMO]);

endmodule

// File: tb/otg_evt_irq_bench.sv
module otg_evt_irq_bench;

  localparam int CPM  = 4;
  localparam int SE0L = 2 * CPM;
  localparam int IDLL = 3 * CPM;
  localparam int RMAX = IDLL + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  line = 2'b10;
  logic        tmo = 0, svb = 0, sdl = 0, ssel = 0, rmt = 0, bsv = 0, asv = 0;
  logic        wen = 0;
  logic [15:0] wdat = '0;
  logic [15:0] stat;
  logic        irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R10";

  otg_evt_irq #(.CYC_PER_MS(CPM), .SE0_MS(2), .IDLE_MS(3)) u_otg_evt_irq (
    .clk(clk), .rst(rst), .line_st_i(line), .tmr_tmo_i(tmo),
    .srp_vbus_i(svb), .srp_dline_i(sdl), .srp_sel_dline_i(ssel),
    .rmt_conn_i(rmt), .b_sess_vld_i(bsv), .a_sess_vld_i(asv),
    .wr_en_i(wen), .wr_data_i(wdat), .stat_o(stat), .irq_o(irq));

  always #5 clk = ~clk;

  // behavioural reference model
  logic [15:0] m_stat;
  logic        m_irq;
  logic [1:0]  m_ls, m_prev;
  int          m_run;
  logic        m_susp;
  logic [2:0]  m_lv;

  always @(posedge clk) begin
    logic [15:0] ev;
    logic        idle_fire;
    if (rst) begin
      m_stat = '0; m_irq = 0; m_ls = 2'b00; m_prev = 2'b00;
      m_run = 0; m_susp = 0; m_lv = '0;
    end else begin
      ev = '0;
      if (tmo) ev[10] = 1;
      if (ssel ? sdl : svb) ev[8] = 1;
      if (rmt != m_lv[2]) ev[5] = 1;
      if (bsv != m_lv[1]) ev[4] = 1;
      if (asv != m_lv[0]) ev[3] = 1;
      m_lv = {rmt, bsv, asv};
      if (m_ls == 2'b00 && m_run == SE0L) ev[9] = 1;
      idle_fire = (m_ls == 2'b01 && m_run == IDLL);
      if (idle_fire) ev[6] = 1;
      if (m_susp && m_ls == 2'b10 && m_prev == 2'b01) ev[7] = 1;
      if (idle_fire) m_susp = 1;
      else if (m_ls != 2'b01) m_susp = 0;
      m_prev = m_ls;
      if (line != m_ls) begin m_ls = line; m_run = 0; end
      else if (m_run < RMAX) m_run++;
      m_stat = ((m_stat & ~(wen ? wdat : 16'h0)) | ev) & 16'h07F8;
      m_irq  = |m_stat;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(cur_req, stat, m_stat);
    chk(cur_req, {15'b0, irq}, {15'b0, m_irq});
    if (cyc > 50000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wen = 1; wdat = d;
    @(negedge clk); wen = 0; wdat = '0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic hold(logic [1:0] ls, int n);
    @(negedge clk); line = ls;
    step(n - 1);
  endtask

  initial begin
    step(3);
    chk("R10 reset word", stat, 16'h0);
    chk("R10 reset irq", {15'b0, irq}, 16'h0);
    @(negedge clk); rst = 0;
    step(2);

    cur_req = "R8";
    pulse(tmo); step(2);
    chk("R8 timeout", stat, 16'h0400);
    chk("R10 irq set", {15'b0, irq}, 16'h1);
    cur_req = "R2";
    wr(16'h0000); step(1);
    chk("R2 write0 keeps", stat, 16'h0400);
    wr(16'h0400); step(1);
    chk("R2 write1 clears", stat, 16'h0);

    cur_req = "R1";
    wr(16'hFFFF); step(1);
    chk("R1 reserved after ones", stat, 16'h0);

    cur_req = "R3";
    hold(2'b00, SE0L); hold(2'b10, 4);
    chk("R3 exact limit no flag", stat, 16'h0);
    hold(2'b00, SE0L + 1); hold(2'b10, 4);
    chk("R3 over limit", stat, 16'h0200);
    wr(16'h0200);
    cur_req = "R11";
    hold(2'b00, 3 * SE0L);
    wr(16'h0200);
    hold(2'b00, 3 * SE0L);
    chk("R11 once per run", stat, 16'h0);
    hold(2'b10, 3);

    cur_req = "R4";
    hold(2'b01, IDLL + 8);
    chk("R4 suspend", stat, 16'h0040);
    cur_req = "R5";
    hold(2'b10, 3);
    chk("R5 resume in suspend", stat, 16'h00C0);
    wr(16'h00C0);
    hold(2'b01, 5); hold(2'b10, 3);
    chk("R5 no resume outside suspend", stat, 16'h0);
    cur_req = "R4";
    hold(2'b01, IDLL + 4); hold(2'b00, 2); hold(2'b10, 2);
    hold(2'b01, 2); hold(2'b10, 3);
    chk("R4 suspend left on SE0", stat, 16'h0040);
    wr(16'h0040); step(1);

    cur_req = "R6";
    ssel = 0; pulse(sdl); step(1);
    chk("R6 dline ignored sel0", stat, 16'h0);
    pulse(svb); step(1);
    chk("R6 vbus sel0", stat, 16'h0100);
    wr(16'h0100);
    @(negedge clk); ssel = 1;
    pulse(svb); step(1);
    chk("R6 vbus ignored sel1", stat, 16'h0);
    pulse(sdl); step(1);
    chk("R6 dline sel1", stat, 16'h0100);
    wr(16'h0100);

    cur_req = "R7";
    @(negedge clk); rmt = 1; step(2);
    chk("R7 remote rise", stat, 16'h0020);
    wr(16'h0020);
    @(negedge clk); rmt = 0; step(2);
    chk("R7 remote fall", stat, 16'h0020);
    @(negedge clk); bsv = 1; step(2);
    chk("R7 bsess rise", stat, 16'h0030);
    @(negedge clk); asv = 1; step(2);
    chk("R7 asess rise", stat, 16'h0038);
    wr(16'h0038);
    @(negedge clk); asv = 0; bsv = 0; step(2);
    chk("R7 both fall", stat, 16'h0018);
    wr(16'h0018); step(1);

    cur_req = "R9";
    pulse(tmo); step(1);
    @(negedge clk); wen = 1; wdat = 16'h0400; tmo = 1;
    @(negedge clk); wen = 0; wdat = '0; tmo = 0;
    step(1);
    chk("R9 event beats clear", stat, 16'h0400);

    cur_req = "R10";
    @(negedge clk); rmt = 1; step(2);
    chk("R10 irq with flags", {15'b0, irq}, 16'h1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 reset clears word", stat, 16'h0);
    chk("R10 reset clears irq", {15'b0, irq}, 16'h0);
    step(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule